// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller with Instruction Decoder

This block is the serial test port of a chip. A 16-state controller advances on the rising edge of the test clock under the mode-select input. A 10-bit instruction register picks which data register sits between the serial input and the serial output. The choices are a one-bit pass-through stage, a 32-bit identification word, a 32-bit user word, or a boundary chain that holds one bit per pin. The serial output changes on the falling edge of the test clock and is enabled only while a register is being shifted.

The decoder also drives several pin-control side outputs. One puts all user pins into high impedance. One lets the pins follow the boundary update stage, either for an external interconnect test or to hold the pins at fixed values. One requests a single-clock reconfiguration pulse without touching the physical configuration pin. The last holds the configuration status low until the configuration engine reports that it has finished. These outputs change only when a new instruction is committed, or when the controller returns to its reset state. The pins, the configuration engine and any debug hooks sit outside the block and consume these flags.

There is no data stream here, so no valid/ready handshake is used. Every pin is a plain level sampled on the test clock, and the shift rate is set by whoever drives the clock.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller state advances on the rising edge of `tck` following the standard mode-select transitions. Five consecutive rising edges with `tms` high bring it to the reset state from any state. A low on `trst_n` forces the reset state at once and clears all side outputs.
- R2: On Capture-IR the instruction shift stage loads 0b0000000001. In Shift-IR it shifts toward the LSB, taking `tdi` into bit 9 and presenting bit 0 on `tdo`, so the captured pattern leaves LSB first.
- R3: A shifted instruction becomes active only on the rising edge that leaves Update-IR. While the controller is in the reset state, the active instruction becomes the identification instruction (code 0x006).
- R4: The codes 0x3FF (bypass), 0x00B, 0x00A, 0x001, 0x00D and every unlisted code select the one-bit pass-through stage. This stage loads 0 on Capture-DR, so a scan of n bits returns 0 followed by the first n-1 input bits.
- R5: Code 0x006 captures the 32-bit identification value and shifts it out LSB first.
- R6: Code 0x007 captures the 32-bit user value and shifts it out LSB first.
- R7: Code 0x005 captures `pin_in` into the boundary chain (bit 0 leaves first) and copies the chain into `pin_out` on Update-DR, while `pins_drive_bsr` stays low.
- R8: Code 0x000 selects the boundary chain with the same capture and update behaviour as R7 and raises `pins_drive_bsr`.
- R9: Code 0x00B raises `pins_tristate` for as long as it is the active instruction, and the flag changes only at an instruction commit or in the reset state.
- R10: Code 0x00A raises `pins_drive_bsr` with `pin_out` unchanged from the update stage, while the pass-through stage is the selected data path.
- R11: Committing code 0x001 raises `reconfig_req` for exactly one `tck` cycle.
- R12: Committing code 0x00D sets `cfg_status_hold`, which stays high until a rising edge with `cfg_done` high. If `cfg_busy` is high at the commit, `cfg_abort` is also set, and it clears together with the hold.
- R13: `tdo` and `tdo_oe` update on the falling edge of `tck`. `tdo_oe` is high only in Shift-IR and Shift-DR, and `tdo` is 0 whenever it is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for `tdo` |
| pin_in | input | BSR_LEN | Pin states captured into the boundary chain |
| pin_out | output | BSR_LEN | Boundary update stage, the values to drive onto the pins |
| pins_drive_bsr | output | 1 | Pins follow `pin_out` (external test or clamp) |
| pins_tristate | output | 1 | All user pins in high impedance |
| reconfig_req | output | 1 | One-cycle reconfiguration request |
| cfg_busy | input | 1 | Configuration currently in progress |
| cfg_done | input | 1 | Reconfiguration finished, releases the hold |
| cfg_status_hold | output | 1 | Hold configuration status low |
| cfg_abort | output | 1 | Configuration stopped by the I/O-setup instruction |

## Verification
If the controller state goes wrong, `tdo_oe` shows it on the next falling edge: it opens or closes in the wrong cycle, and a scan returns a misaligned word. A wrong active instruction appears at once on the pin-control flags. It also shows on the first bit of the next data scan, where the pass-through stage returns 0 but the identification, user and boundary registers return their captured bits. Errors in the hold and pulse logic appear at the rising edge after the commit, or only at the `cfg_done` edge, so the bench compares every output against its model on every clock rather than only at the end of a scan.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_USER, SEL_BSR} dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    tristate;
    logic    drive_bsr;
    logic    pulse;
    logic    cfg_io;
  } instr_dec_t;

  localparam logic [IR_W-1:0] OP_EXTEST  = 10'h000;
  localparam logic [IR_W-1:0] OP_PULSE   = 10'h001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 10'h005;
  localparam logic [IR_W-1:0] OP_IDENT   = 10'h006;
  localparam logic [IR_W-1:0] OP_USER    = 10'h007;
  localparam logic [IR_W-1:0] OP_HOLDPIN = 10'h00A;
  localparam logic [IR_W-1:0] OP_FLOAT   = 10'h00B;
  localparam logic [IR_W-1:0] OP_IOSETUP = 10'h00D;
  localparam logic [IR_W-1:0] OP_BYPASS  = 10'h3FF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 10'b0000000001;

  function automatic instr_dec_t decode_op(input logic [IR_W-1:0] op, input logic has_id);
    instr_dec_t d;
    d.sel       = SEL_BYP;
    d.tristate  = 1'b0;
    d.drive_bsr = 1'b0;
    d.pulse     = 1'b0;
    d.cfg_io    = 1'b0;
    case (op)
      OP_EXTEST:  begin d.sel = SEL_BSR; d.drive_bsr = 1'b1; end
      OP_SAMPLE:  d.sel = SEL_BSR;
      OP_IDENT:   d.sel = has_id ? SEL_ID : SEL_BYP;
      OP_USER:    d.sel = SEL_USER;
      OP_HOLDPIN: d.drive_bsr = 1'b1;
      OP_FLOAT:   d.tristate = 1'b1;
      OP_PULSE:   d.pulse = 1'b1;
      OP_IOSETUP: d.cfg_io = 1'b1;
      default:    d.sel = SEL_BYP;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= nxt;
  end

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
#(
  parameter bit HAS_ID = 1'b1
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic            ir_lsb,
  output logic [IR_W-1:0] ir_code,
  output instr_dec_t      dec_act,
  output instr_dec_t      dec_pend
);

  localparam logic [IR_W-1:0] RST_OP = HAS_ID ? OP_IDENT : OP_BYPASS;

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh   <= '0;
      ir_code <= RST_OP;
    end else begin
      case (state)
        ST_RESET:  ir_code <= RST_OP;
        ST_CAP_IR: ir_sh   <= IR_CAPTURE;
        ST_SH_IR:  ir_sh   <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPD_IR: ir_code <= ir_sh;
        default:   ;
      endcase
    end
  end

  assign ir_lsb   = ir_sh[0];
  assign dec_act  = decode_op(ir_code, HAS_ID);
  assign dec_pend = decode_op(ir_sh, HAS_ID);

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int          BSR_LEN    = 8,
  parameter int          WORD_W     = 32,
  parameter bit          HAS_ID     = 1'b1,
  parameter logic [31:0] ID_VALUE   = 32'h0A3C_50DD,
  parameter logic [31:0] USER_VALUE = 32'hC0DE_2468
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state,
  input  dr_sel_e            sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] pin_out,
  output logic               dr_lsb
);

  logic               byp;
  logic [WORD_W-1:0]  id_sh;
  logic [WORD_W-1:0]  user_sh;
  logic [BSR_LEN-1:0] bsr_sh;

  generate
    if (HAS_ID) begin : g_id
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) id_sh <= '0;
        else if (sel == SEL_ID) begin
          if (state == ST_CAP_DR)     id_sh <= ID_VALUE[WORD_W-1:0];
          else if (state == ST_SH_DR) id_sh <= {tdi, id_sh[WORD_W-1:1]};
        end
      end
    end else begin : g_no_id
      assign id_sh = '0;
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp     <= 1'b0;
      user_sh <= '0;
      bsr_sh  <= '0;
      pin_out <= '0;
    end else begin
      case (state)
        ST_CAP_DR: begin
          case (sel)
            SEL_BYP:  byp     <= 1'b0;
            SEL_USER: user_sh <= USER_VALUE[WORD_W-1:0];
            SEL_BSR:  bsr_sh  <= pin_in;
            default:  ;
          endcase
        end
        ST_SH_DR: begin
          case (sel)
            SEL_BYP:  byp     <= tdi;
            SEL_USER: user_sh <= {tdi, user_sh[WORD_W-1:1]};
            SEL_BSR:  bsr_sh  <= {tdi, bsr_sh[BSR_LEN-1:1]};
            default:  ;
          endcase
        end
        ST_UPD_DR: if (sel == SEL_BSR) pin_out <= bsr_sh;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_ID:   dr_lsb = id_sh[0];
      SEL_USER: dr_lsb = user_sh[0];
      SEL_BSR:  dr_lsb = bsr_sh[0];
      default:  dr_lsb = byp;
    endcase
  end

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int          BSR_LEN    = 8,
  parameter bit          HAS_ID     = 1'b1,
  parameter logic [31:0] ID_VALUE   = 32'h0A3C_50DD,
  parameter logic [31:0] USER_VALUE = 32'hC0DE_2468
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] pin_out,
  output logic               pins_drive_bsr,
  output logic               pins_tristate,
  output logic               reconfig_req,
  input  logic               cfg_busy,
  input  logic               cfg_done,
  output logic               cfg_status_hold,
  output logic               cfg_abort
);

  tap_state_e      tap_state;
  logic            ir_lsb;
  logic            dr_lsb;
  logic [IR_W-1:0] ir_code;
  instr_dec_t      dec_act;
  instr_dec_t      dec_pend;
  logic            commit;
  logic            shifting;

  jtag_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (tap_state)
  );

  jtag_tap_ir #(.HAS_ID(HAS_ID)) u_ir (
    .tck      (tck),
    .trst_n   (trst_n),
    .state    (tap_state),
    .tdi      (tdi),
    .ir_lsb   (ir_lsb),
    .ir_code  (ir_code),
    .dec_act  (dec_act),
    .dec_pend (dec_pend)
  );

  jtag_tap_dr #(
    .BSR_LEN    (BSR_LEN),
    .HAS_ID     (HAS_ID),
    .ID_VALUE   (ID_VALUE),
    .USER_VALUE (USER_VALUE)
  ) u_dr (
    .tck     (tck),
    .trst_n  (trst_n),
    .state   (tap_state),
    .sel     (dec_act.sel),
    .tdi     (tdi),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .dr_lsb  (dr_lsb)
  );

  assign commit   = (tap_state == ST_UPD_IR);
  assign shifting = (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);

  assign pins_tristate  = dec_act.tristate;
  assign pins_drive_bsr = dec_act.drive_bsr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      reconfig_req    <= 1'b0;
      cfg_status_hold <= 1'b0;
      cfg_abort       <= 1'b0;
    end else begin
      reconfig_req <= commit && dec_pend.pulse;
      if (commit && dec_pend.cfg_io) begin
        cfg_status_hold <= 1'b1;
        if (cfg_busy) cfg_abort <= 1'b1;
      end else if (cfg_done) begin
        cfg_status_hold <= 1'b0;
        cfg_abort       <= 1'b0;
      end
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shifting;
      if (!shifting)                  tdo <= 1'b0;
      else if (tap_state == ST_SH_IR) tdo <= ir_lsb;
      else                            tdo <= dr_lsb;
    end
  end

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input tap_state_e state,
  input logic       tdo_oe,
  input logic       pins_tristate,
  input logic       reconfig_req,
  input logic       cfg_done,
  input logic       cfg_status_hold,
  input logic       cfg_abort
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       ones_cnt <= '0;
    else if (!tms)     ones_cnt <= '0;
    else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
  end

  p_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt >= 3'd5) |-> (state == ST_RESET));

  p_oe_shift_r13: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((state == ST_SH_IR) || (state == ST_SH_DR)));

  p_float_commit_r9: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(pins_tristate) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET));

  p_pulse_single_r11: assert property (@(posedge tck) disable iff (!trst_n)
    reconfig_req |=> !reconfig_req);

  p_hold_set_r12: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(cfg_status_hold) |-> ($past(state) == ST_UPD_IR));

  p_hold_keep_r12: assert property (@(posedge tck) disable iff (!trst_n)
    (cfg_status_hold && !cfg_done) |=> cfg_status_hold);

  p_abort_hold_r12: assert property (@(posedge tck) disable iff (!trst_n)
    cfg_abort |-> cfg_status_hold);

endmodule

bind jtag_tap_ctrl jtag_tap_chk u_chk (
  .tck             (tck),
  .trst_n          (trst_n),
  .tms             (tms),
  .state           (tap_state),
  .tdo_oe          (tdo_oe),
  .pins_tristate   (pins_tristate),
  .reconfig_req    (reconfig_req),
  .cfg_done        (cfg_done),
  .cfg_status_hold (cfg_status_hold),
  .cfg_abort       (cfg_abort)
);

// File: tb/test_jtag_tap_ctrl.sv
`timescale 1ns/1ps
module test_jtag_tap_ctrl;

  localparam int N = 8;
  localparam logic [31:0] IDV  = 32'h0A3C_50DD;
  localparam logic [31:0] USRV = 32'hC0DE_2468;

  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                 S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                 S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;
  logic pins_drive_bsr, pins_tristate, reconfig_req;
  logic cfg_busy = 1'b0;
  logic cfg_done = 1'b0;
  logic cfg_status_hold, cfg_abort;

  int total = 0;
  int bad = 0;
  bit cmp_en = 0;

  always #10 tck = ~tck;

  jtag_tap_ctrl #(.BSR_LEN(N), .ID_VALUE(IDV), .USER_VALUE(USRV)) i_jtag_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pins_drive_bsr(pins_drive_bsr),
    .pins_tristate(pins_tristate), .reconfig_req(reconfig_req), .cfg_busy(cfg_busy),
    .cfg_done(cfg_done), .cfg_status_hold(cfg_status_hold), .cfg_abort(cfg_abort)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mstate;
  logic [9:0] mir, mir_sh;
  logic [31:0] mdr;
  int mlen;
  logic [N-1:0] mpins;
  logic mpulse, mhold, mabort;

  function automatic int step_state(input int s, input logic m);
    case (s)
      S_TLR:  return m ? S_TLR : S_RTI;
      S_RTI:  return m ? S_SDR : S_RTI;
      S_SDR:  return m ? S_SIR : S_CDR;
      S_CDR, S_SHDR: return m ? S_E1DR : S_SHDR;
      S_E1DR: return m ? S_UDR : S_PDR;
      S_PDR:  return m ? S_E2DR : S_PDR;
      S_E2DR: return m ? S_UDR : S_SHDR;
      S_UDR, S_UIR: return m ? S_SDR : S_RTI;
      S_SIR:  return m ? S_TLR : S_CIR;
      S_CIR, S_SHIR: return m ? S_E1IR : S_SHIR;
      S_E1IR: return m ? S_UIR : S_PIR;
      S_PIR:  return m ? S_E2IR : S_PIR;
      S_E2IR: return m ? S_UIR : S_SHIR;
      default: return S_TLR;
    endcase
  endfunction

  // 0 pass-through, 1 ident, 2 user, 3 boundary chain
  function automatic int kind(input logic [9:0] c);
    if (c == 10'h006) return 1;
    if (c == 10'h007) return 2;
    if (c == 10'h000 || c == 10'h005) return 3;
    return 0;
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      mstate = S_TLR; mir = 10'h006; mir_sh = '0; mdr = '0; mlen = 1;
      mpins = '0; mpulse = 0; mhold = 0; mabort = 0;
    end else begin
      mpulse = 0;
      if (!(mstate == S_UIR && mir_sh == 10'h00D) && cfg_done) begin
        mhold = 0; mabort = 0;
      end
      case (mstate)
        S_TLR:  mir = 10'h006;
        S_CIR:  mir_sh = 10'h001;
        S_SHIR: mir_sh = {tdi, mir_sh[9:1]};
        S_UIR: begin
          mir = mir_sh;
          if (mir_sh == 10'h001) mpulse = 1;
          if (mir_sh == 10'h00D) begin mhold = 1; if (cfg_busy) mabort = 1; end
        end
        S_CDR: begin
          case (kind(mir))
            1: begin mdr = IDV; mlen = 32; end
            2: begin mdr = USRV; mlen = 32; end
            3: begin mdr = 32'(pin_in); mlen = N; end
            default: begin mdr = 0; mlen = 1; end
          endcase
        end
        S_SHDR: begin
          mdr = mdr >> 1;
          mdr[mlen-1] = tdi;
        end
        S_UDR: if (kind(mir) == 3) mpins = mdr[N-1:0];
        default: ;
      endcase
      mstate = step_state(mstate, tms);
    end
  end

  always @(negedge tck) begin
    #8;
    if (cmp_en) begin
      logic eoe, etdo;
      eoe  = (mstate == S_SHIR) || (mstate == S_SHDR);
      etdo = !eoe ? 1'b0 : (mstate == S_SHIR ? mir_sh[0] : mdr[0]);
      check("R13 model tdo_oe", 32'(tdo_oe), 32'(eoe));
      check("R13 model tdo", 32'(tdo), 32'(etdo));
      check("R9 model tristate", 32'(pins_tristate), 32'(mir == 10'h00B));
      check("R8/R10 model drive", 32'(pins_drive_bsr), 32'(mir == 10'h000 || mir == 10'h00A));
      check("R7 model pin_out", 32'(pin_out), 32'(mpins));
      check("R11 model pulse", 32'(reconfig_req), 32'(mpulse));
      check("R12 model hold", 32'(cfg_status_hold), 32'(mhold));
      check("R12 model abort", 32'(cfg_abort), 32'(mabort));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input logic t, input logic d, output logic o);
    @(negedge tck); #1; tms = t; tdi = d; #7; o = tdo;
    @(posedge tck);
  endtask

  task automatic load_ir(input logic [9:0] code, output logic [9:0] cap);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 10; i++) begin
      tick(i == 9, code[i], o);
      cap[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic o;
    dout = '0;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o);
      dout[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] cap;
    logic [31:0] dout;
    logic o;

    repeat (3) @(posedge tck);
    #1;
    check("R1 reset tdo_oe", 32'(tdo_oe), 0);
    check("R1 reset tristate", 32'(pins_tristate), 0);
    check("R1 reset drive", 32'(pins_drive_bsr), 0);
    check("R1 reset hold", 32'(cfg_status_hold), 0);
    @(negedge tck); #1; trst_n = 1; cmp_en = 1;
    tick(0, 0, o);

    scan_dr(32, 0, dout);
    check("R3 R5 ident after reset", dout, IDV);

    load_ir(10'h007, cap);
    check("R2 IR capture pattern", 32'(cap), 32'h001);
    scan_dr(32, 0, dout);
    check("R6 user word", dout, USRV);

    load_ir(10'h3FF, cap);
    scan_dr(4, 32'hB, dout);
    check("R4 bypass delay", dout, 32'h6);

    load_ir(10'h123, cap);
    scan_dr(4, 32'h9, dout);
    check("R4 unlisted code bypass", dout, 32'h2);

    pin_in = 8'hA5;
    load_ir(10'h005, cap);
    scan_dr(N, 32'h3C, dout);
    check("R7 sample capture", dout, 32'hA5);
    #1;
    check("R7 preload pin_out", 32'(pin_out), 32'h3C);
    check("R7 no drive", 32'(pins_drive_bsr), 0);

    load_ir(10'h000, cap);
    #1;
    check("R8 extest drive", 32'(pins_drive_bsr), 1);
    pin_in = 8'h5A;
    scan_dr(N, 32'hF0, dout);
    check("R8 extest capture", dout, 32'h5A);
    #1;
    check("R8 extest update", 32'(pin_out), 32'hF0);

    load_ir(10'h00B, cap);
    #1;
    check("R9 float flag", 32'(pins_tristate), 1);
    check("R9 float no drive", 32'(pins_drive_bsr), 0);
    scan_dr(2, 32'h1, dout);
    check("R4 R9 float bypass", dout, 32'h2);

    load_ir(10'h00A, cap);
    #1;
    check("R10 clamp drive", 32'(pins_drive_bsr), 1);
    check("R10 clamp tristate off", 32'(pins_tristate), 0);
    scan_dr(3, 32'h7, dout);
    check("R10 clamp bypass path", dout, 32'h6);
    #1;
    check("R10 clamp pins held", 32'(pin_out), 32'hF0);

    load_ir(10'h001, cap);
    #1;
    check("R11 pulse high", 32'(reconfig_req), 1);
    tick(0, 0, o); #1;
    check("R11 pulse one cycle", 32'(reconfig_req), 0);

    cfg_busy = 1;
    load_ir(10'h00D, cap);
    #1;
    check("R12 hold set", 32'(cfg_status_hold), 1);
    check("R12 abort set", 32'(cfg_abort), 1);
    cfg_busy = 0;
    load_ir(10'h3FF, cap);
    #1;
    check("R12 hold kept", 32'(cfg_status_hold), 1);
    @(negedge tck); #1; cfg_done = 1;
    @(posedge tck); #1;
    check("R12 hold released", 32'(cfg_status_hold), 0);
    check("R12 abort released", 32'(cfg_abort), 0);
    @(negedge tck); #1; cfg_done = 0;
    load_ir(10'h00D, cap);
    #1;
    check("R12 hold idle config", 32'(cfg_status_hold), 1);
    check("R12 no abort when idle", 32'(cfg_abort), 0);

    load_ir(10'h00B, cap);
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 5; i++) tick(1, 0, o);
    #1;
    check("R1 R3 tms reset clears float", 32'(pins_tristate), 0);
    tick(0, 0, o);
    scan_dr(32, 0, dout);
    check("R1 R3 ident after tms reset", dout, IDV);

    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    #1;
    check("R13 oe waits for falling edge", 32'(tdo_oe), 0);
    @(negedge tck); #1; tms = 0;
    check("R13 oe in shift", 32'(tdo_oe), 1);
    check("R13 first bit", 32'(tdo), 32'(IDV[0]));
    @(posedge tck); #1;
    check("R13 tdo held over rising edge", 32'(tdo), 32'(IDV[0]));
    @(negedge tck); #1;
    check("R13 tdo moves on falling edge", 32'(tdo), 32'(IDV[1]));
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o);

    @(negedge tck); #1; trst_n = 0; cmp_en = 0;
    #2;
    check("R1 trst clears hold", 32'(cfg_status_hold), 0);
    @(negedge tck); #1; trst_n = 1; cmp_en = 1;
    tick(0, 0, o);
    repeat (3) tick(0, 0, o);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule